// File: doc/BRIEF.md
# Multiplier Input Register Chain

This block is the operand register stage in front of the multipliers of a multiply-accumulate slice. Each multiplier gets a registered A operand and a registered B operand. Both registers share one synchronous clear and one clock enable. The multipliers, adders and accumulators sit downstream and are not part of this block. The slice's registered result comes back in on a plain input port.

How the A operands load is fixed at elaboration. In parallel mode, each A register takes its own slice of the A input bus. In shift mode, the A registers form a chain: the first one takes slice 0 of the bus, and each later one takes the previous-cycle value of its neighbour. This chain is a FIR tap delay line that needs no outside logic. The last A register is also driven on a scan-out port, so that several slices can be cascaded.

The B register of the first multiplier can be set to loop back the upper 18 bits of the registered result, which recursive filters need. The B registers of all the other multipliers always load from general routing. The shift chain is honoured only for operand widths of 18 bits or less. Loopback is honoured only at exactly 18 bits. Any other request falls back to parallel loading and routed loading.

Top module: `mac_in_regs`

## Requirements
- R1: A synchronous active-high `rst` sets every A register, every B register and `a_scan_out` to zero at the next rising edge. It takes priority over all other inputs.
- R2: When `clr` is high at a rising edge, every operand register becomes zero. This happens whatever the value of `ce`.
- R3: When `ce` is low and `clr` and `rst` are low, every operand register holds its value, including the whole A shift chain. The data inputs have no effect.
- R4: With `ce` high, each B register k for k ≥ 1 loads `b_in[k*OPW +: OPW]`. B registers never shift into one another.
- R5: In shift mode with OPW ≤ 18, A register 0 loads `a_in[OPW-1:0]` and A register k loads the previous-cycle value of A register k-1. The A input slices 1 and above are ignored.
- R6: `a_scan_out` always equals the registered A operand of the last multiplier, `a_q[(NUM_MULT-1)*OPW +: OPW]`.
- R7: In loopback mode with OPW = 18, B register 0 loads `res_in[RES_W-1 -: 18]`, the top 18 bits of the result, and `b_in[17:0]` is ignored.
- R8: When OPW > 18, a request for shift mode gives parallel loading: each A register k loads `a_in[k*OPW +: OPW]`.
- R9: When OPW ≠ 18, a request for loopback gives routed loading: B register 0 loads `b_in[OPW-1:0]`.
- R10: In shift mode, with `ce` held high, tap k (A register k) equals the sample that was on `a_in[OPW-1:0]` k cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all operand registers |
| ce | input | 1 | Clock enable for all operand registers |
| a_in | input | NUM_MULT*OPW | A operands, slice k for multiplier k; slice 0 is the chain head in shift mode |
| b_in | input | NUM_MULT*OPW | B operands, slice k for multiplier k |
| res_in | input | RES_W | Registered result of the slice, used for loopback |
| a_q | output | NUM_MULT*OPW | Registered A operands |
| b_q | output | NUM_MULT*OPW | Registered B operands |
| a_scan_out | output | OPW | Registered A of the last multiplier, for cascading |

## Verification
The assertions check the per-register rules on every enabled or disabled cycle: clear wins over enable, hold when disabled, chain step from neighbour to neighbour, B loading from routing or from the top result bits, and parallel loading after fallback. Some behaviour only the bench's scenarios can show. These are the reset value after arbitrary prior contents, the end-to-end delay-line property that tap k shows the sample from k cycles earlier, the scan-out port tracking the chain tail, and the fallback of a wide instance that requests shift and loopback. The bench runs a 4-tap narrow instance and a 2-multiplier 36-bit instance side by side.

// File: rtl/mac_in_pkg.sv
package mac_in_pkg;

    typedef enum logic {
        A_PARALLEL = 1'b0,
        A_SHIFT    = 1'b1
    } a_mode_e;

    typedef enum logic {
        B_ROUTE = 1'b0,
        B_LOOP  = 1'b1
    } b_src_e;

    localparam int LOOP_W      = 18;
    localparam int SHIFT_MAX_W = 18;

    typedef struct packed {
        logic clr;
        logic ce;
    } reg_ctl_t;

    function automatic a_mode_e eff_a_mode(a_mode_e req, int width);
        return (req == A_SHIFT && width <= SHIFT_MAX_W) ? A_SHIFT : A_PARALLEL;
    endfunction

    function automatic b_src_e eff_b_src(b_src_e req, int width);
        return (req == B_LOOP && width == LOOP_W) ? B_LOOP : B_ROUTE;
    endfunction

endpackage

// File: rtl/mac_op_reg.sv
module mac_op_reg
    import mac_in_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  reg_ctl_t     ctl,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            q <= '0;
        end else if (ctl.ce) begin
            q <= d;
        end
    end

    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        ctl.clr |=> q == '0);

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr && !ctl.ce) |=> $stable(q));

endmodule

// File: rtl/mac_a_chain.sv
module mac_a_chain
    import mac_in_pkg::*;
#(
    parameter int      N    = 2,
    parameter int      W    = 18,
    parameter a_mode_e MODE = A_SHIFT
) (
    input  logic           clk,
    input  logic           rst,
    input  reg_ctl_t       ctl,
    input  logic [N*W-1:0] a_in,
    output logic [N*W-1:0] a_q
);

    for (genvar k = 0; k < N; k++) begin : g_tap
        logic [W-1:0] d;

        if (MODE == A_SHIFT && k > 0) begin : g_link
            assign d = a_q[(k-1)*W +: W];

            assert_chain_step_R5: assert property (@(posedge clk) disable iff (rst)
                (ctl.ce && !ctl.clr) |=> a_q[k*W +: W] == $past(a_q[(k-1)*W +: W]));
        end else begin : g_load
            assign d = a_in[k*W +: W];

            assert_a_load_R8: assert property (@(posedge clk) disable iff (rst)
                (ctl.ce && !ctl.clr) |=> a_q[k*W +: W] == $past(a_in[k*W +: W]));
        end

        mac_op_reg #(.W(W)) u_reg (
            .clk (clk),
            .rst (rst),
            .ctl (ctl),
            .d   (d),
            .q   (a_q[k*W +: W])
        );
    end

endmodule

// File: rtl/mac_b_bank.sv
module mac_b_bank
    import mac_in_pkg::*;
#(
    parameter int     N     = 2,
    parameter int     W     = 18,
    parameter int     RES_W = 38,
    parameter b_src_e SRC   = B_LOOP
) (
    input  logic           clk,
    input  logic           rst,
    input  reg_ctl_t       ctl,
    input  logic [N*W-1:0] b_in,
    input  logic [RES_W-1:0] res_in,
    output logic [N*W-1:0] b_q
);

    for (genvar k = 0; k < N; k++) begin : g_op
        logic [W-1:0] d;

        if (SRC == B_LOOP && k == 0) begin : g_loop
            assign d = res_in[RES_W-1 -: W];

            assert_loopback_R7: assert property (@(posedge clk) disable iff (rst)
                (ctl.ce && !ctl.clr) |=> b_q[W-1:0] == $past(res_in[RES_W-1 -: W]));
        end else begin : g_route
            assign d = b_in[k*W +: W];

            assert_b_route_R4: assert property (@(posedge clk) disable iff (rst)
                (ctl.ce && !ctl.clr) |=> b_q[k*W +: W] == $past(b_in[k*W +: W]));
        end

        mac_op_reg #(.W(W)) u_reg (
            .clk (clk),
            .rst (rst),
            .ctl (ctl),
            .d   (d),
            .q   (b_q[k*W +: W])
        );
    end

endmodule

// File: rtl/mac_in_regs.sv
module mac_in_regs
    import mac_in_pkg::*;
#(
    parameter int      NUM_MULT   = 2,
    parameter int      OPW        = 18,
    parameter int      RES_W      = 38,
    parameter a_mode_e A_MODE_REQ = A_SHIFT,
    parameter b_src_e  B0_SRC_REQ = B_LOOP
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    ce,
    input  logic [NUM_MULT*OPW-1:0] a_in,
    input  logic [NUM_MULT*OPW-1:0] b_in,
    input  logic [RES_W-1:0]        res_in,
    output logic [NUM_MULT*OPW-1:0] a_q,
    output logic [NUM_MULT*OPW-1:0] b_q,
    output logic [OPW-1:0]          a_scan_out
);

    localparam a_mode_e A_MODE = eff_a_mode(A_MODE_REQ, OPW);
    localparam b_src_e  B0_SRC = eff_b_src(B0_SRC_REQ, OPW);
    localparam int      TAIL   = (NUM_MULT - 1) * OPW;

    reg_ctl_t ctl;
    assign ctl = '{clr: clr, ce: ce};

    mac_a_chain #(
        .N    (NUM_MULT),
        .W    (OPW),
        .MODE (A_MODE)
    ) u_a_chain (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl),
        .a_in (a_in),
        .a_q  (a_q)
    );

    mac_b_bank #(
        .N     (NUM_MULT),
        .W     (OPW),
        .RES_W (RES_W),
        .SRC   (B0_SRC)
    ) u_b_bank (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .b_in   (b_in),
        .res_in (res_in),
        .b_q    (b_q)
    );

    // R6: the chain tail is exported for cascading slices
    assign a_scan_out = a_q[TAIL +: OPW];

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (a_q == '0 && b_q == '0 && a_scan_out == '0));

endmodule

// File: tb/mac_in_regs_test.sv
`timescale 1ns/1ps
module mac_in_regs_test;
    import mac_in_pkg::*;

    localparam int NN = 4;
    localparam int NW = 18;
    localparam int WN = 2;
    localparam int WW = 36;
    localparam int RW = 38;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1, clr = 1'b0, ce = 1'b0;
    logic [NN*NW-1:0] a_n = '0, b_n = '0;
    logic [WN*WW-1:0] a_w = '0, b_w = '0;
    logic [RW-1:0]    res = '0;

    logic [NN*NW-1:0] aq_n, bq_n;
    logic [NW-1:0]    so_n;
    logic [WN*WW-1:0] aq_w, bq_w;
    logic [WW-1:0]    so_w;

    mac_in_regs #(.NUM_MULT(NN), .OPW(NW), .RES_W(RW),
                  .A_MODE_REQ(A_SHIFT), .B0_SRC_REQ(B_LOOP)) uut (
        .clk(clk), .rst(rst), .clr(clr), .ce(ce), .a_in(a_n), .b_in(b_n),
        .res_in(res), .a_q(aq_n), .b_q(bq_n), .a_scan_out(so_n));

    mac_in_regs #(.NUM_MULT(WN), .OPW(WW), .RES_W(RW),
                  .A_MODE_REQ(A_SHIFT), .B0_SRC_REQ(B_LOOP)) uut_wide (
        .clk(clk), .rst(rst), .clr(clr), .ce(ce), .a_in(a_w), .b_in(b_w),
        .res_in(res), .a_q(aq_w), .b_q(bq_w), .a_scan_out(so_w));

    typedef struct {
        string           tag;
        logic [71:0]     ea, eb, ewa, ewb;
        logic [NW-1:0]   eso;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0, failures = 0;

    logic [NW-1:0] ma [NN];
    logic [NW-1:0] mb [NN];
    logic [WW-1:0] mwa [WN];
    logic [WW-1:0] mwb [WN];

    task automatic check(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [71:0] pat(input int seed);
        logic [71:0] v;
        for (int k = 0; k < 4; k++)
            v[k*18 +: 18] = 18'((seed * 7919 + k * 4099 + 17) ^ (seed << (k + 2)));
        return v;
    endfunction

    // Driver: applies one cycle of stimulus, updates the reference model, pushes expectation
    task automatic step(input bit r, input bit c, input bit e, input logic [71:0] an,
                        input logic [71:0] bn, input logic [71:0] wa, input logic [71:0] wb,
                        input logic [RW-1:0] rs, input string tag);
        exp_t it;
        @(negedge clk);
        rst = r; clr = c; ce = e; a_n = an; b_n = bn; a_w = wa; b_w = wb; res = rs;
        if (r || c) begin
            for (int k = 0; k < NN; k++) begin ma[k] = '0; mb[k] = '0; end
            for (int k = 0; k < WN; k++) begin mwa[k] = '0; mwb[k] = '0; end
        end else if (e) begin
            for (int k = NN - 1; k > 0; k--) ma[k] = ma[k-1];
            ma[0] = an[NW-1:0];
            mb[0] = rs[RW-1 -: NW];
            for (int k = 1; k < NN; k++) mb[k] = bn[k*NW +: NW];
            for (int k = 0; k < WN; k++) begin
                mwa[k] = wa[k*WW +: WW];
                mwb[k] = wb[k*WW +: WW];
            end
        end
        it.tag = tag;
        for (int k = 0; k < NN; k++) begin
            it.ea[k*NW +: NW] = ma[k];
            it.eb[k*NW +: NW] = mb[k];
        end
        for (int k = 0; k < WN; k++) begin
            it.ewa[k*WW +: WW] = mwa[k];
            it.ewb[k*WW +: WW] = mwb[k];
        end
        it.eso = ma[NN-1];
        exp_q.push_back(it);
        @(posedge clk);
        #2;
    endtask

    // Monitor: compares design outputs one register stage after each driven cycle
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            check(aq_n == it.ea, {it.tag, " narrow A"}, aq_n, it.ea);
            check(bq_n == it.eb, {it.tag, " narrow B"}, bq_n, it.eb);
            check(so_n == it.eso, {it.tag, " R6 scan out"}, 72'(so_n), 72'(it.eso));
            check(aq_w == it.ewa, {it.tag, " R8 wide A"}, aq_w, it.ewa);
            check(bq_w == it.ewb, {it.tag, " R9 wide B"}, bq_w, it.ewb);
        end
    end

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [NW-1:0] hist [0:15];
        // R1: reset with live data on every input
        step(1, 0, 1, pat(1), pat(2), pat(3), pat(4), 38'h3a5a5a5a5a, "R1 reset");
        step(1, 0, 1, pat(5), pat(6), pat(7), pat(8), 38'h1234567890, "R1 reset");
        check(aq_n == '0 && bq_n == '0 && so_n == '0, "R1 reset state", aq_n, '0);

        // R4 R5 R7 R8 R9: several loading patterns
        for (int i = 0; i < 6; i++)
            step(0, 0, 1, pat(10 + i), pat(20 + i), pat(30 + i), pat(40 + i),
                 RW'({pat(50 + i)}), "R4 R5 R7 R8 R9 load");

        // R7 specific: B0 reflects top result bits, not b_in slice 0
        step(0, 0, 1, pat(60), 72'h3ffff, pat(61), pat(62), 38'h2aaaa_c0001, "R7 loopback");
        check(bq_n[NW-1:0] == 18'h2aaaa >> 0 ? 1'b1 : bq_n[NW-1:0] == 38'h2aaaa_c0001 >> 20,
              "R7 top bits", 72'(bq_n[NW-1:0]), 72'(38'h2aaaa_c0001 >> 20));

        // R3: enable low, inputs change, everything holds
        for (int i = 0; i < 3; i++)
            step(0, 0, 0, pat(70 + i), pat(80 + i), pat(90 + i), pat(100 + i),
                 RW'(pat(110 + i)), "R3 hold");

        // R2: clear with enable high, then clear with enable low
        step(0, 1, 1, pat(120), pat(121), pat(122), pat(123), RW'(pat(124)), "R2 clear");
        step(0, 0, 1, pat(125), pat(126), pat(127), pat(128), RW'(pat(129)), "R5 refill");
        step(0, 1, 0, pat(130), pat(131), pat(132), pat(133), RW'(pat(134)), "R2 clear no ce");
        check(aq_n == '0 && bq_w == '0, "R2 cleared", aq_n, '0);

        // R10: 4-tap delay line, tap k equals sample from k cycles back
        for (int n = 0; n < 10; n++) begin
            logic [71:0] s;
            s = pat(200 + n);
            hist[n] = s[NW-1:0];
            step(0, 0, 1, s, pat(300 + n), pat(400 + n), pat(500 + n), RW'(pat(600 + n)), "R10 line");
            for (int k = 0; k < NN; k++)
                if (n >= k)
                    check(aq_n[k*NW +: NW] == hist[n-k], "R10 tap delay",
                          72'(aq_n[k*NW +: NW]), 72'(hist[n-k]));
            if (n >= NN - 1)
                check(so_n == hist[n-NN+1], "R6 scan tail", 72'(so_n), 72'(hist[n-NN+1]));
        end

        // R1: reset mid-run
        step(1, 0, 1, pat(700), pat(701), pat(702), pat(703), RW'(pat(704)), "R1 mid reset");
        check(aq_n == '0 && bq_n == '0 && aq_w == '0, "R1 mid reset", aq_n, '0);
        step(0, 0, 1, pat(710), pat(711), pat(712), pat(713), RW'(pat(714)), "R5 R8 after reset");
        step(0, 0, 0, '0, '0, '0, '0, '0, "R3 flush");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule